// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block is the part of an I2C master that puts START and STOP conditions on the bus. Software issues a command by writing a status word with master, transmit and busy bits. With the block enabled, a word with master=1, transmit=1 and busy=1 asks for a START. The same word with busy=0 asks for a STOP. The block then steps through setup, hold and flag phases. Each phase lasts a fixed number of system-clock cycles, and that number depends on whether standard or high-speed timing was selected when the command was taken.

The two bus lines are open-drain. Each output is a pull-low request: a 1 pulls the line low and a 0 releases it high. When a START completes, the block hands off to a byte shifter. It loads the bit counter with zero and raises a one-cycle request to begin clocking the first byte. From then on it keeps both lines pulled low until a STOP is issued. The block also keeps a bus-busy flag and a sticky error bit. The error bit records a START asked for on a busy bus or a STOP asked for on an idle bus.

Top module: `i2c_cond_gen`

## Requirements
- R1: After synchronous reset, both pull-low outputs are 0, bus_busy is 0, bit_cnt reads 3'b111, cmd_error is 0 and byte_start is 0.
- R2: When enable is 0, a write strobe has no effect: no line, bus_busy or cmd_error changes.
- R3: START in standard mode: SDA is pulled low 20 cycles after the accepting clock edge, and SCL 20 cycles after that. bus_busy rises 12 cycles after SDA falls.
- R4: START in high-speed mode: the same three intervals are 10, 10 and 6 cycles.
- R5: When a START completes, bit_cnt becomes 3'b000 and byte_start is high for exactly one cycle, in the cycle SCL is first pulled low.
- R6: STOP in standard mode: SDA stays low, SCL is released 20 cycles after the accepting edge, and SDA is released 17 cycles after that. bus_busy falls 12 cycles after SDA rises.
- R7: STOP in high-speed mode: the same three intervals are 10, 7 and 6 cycles.
- R8: mode_fast is sampled only in the cycle a command is accepted. Changing it during a sequence does not alter that sequence's timing.
- R9: A START request while bus_busy=1, or a STOP request while bus_busy=0, is ignored and sets cmd_error. cmd_error stays set until reset.
- R10: A write with wr_mst=0 or wr_trx=0 does nothing. A write that arrives while a sequence is running is ignored and does not set cmd_error.
- R11: After a STOP completes, both lines are released and bus_busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (phase counting reference) |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; writes are ignored when 0 |
| mode_fast | input | 1 | 1 selects high-speed timing, 0 standard |
| wr_stb | input | 1 | Status register write strobe |
| wr_mst | input | 1 | Written master bit |
| wr_trx | input | 1 | Written transmit bit |
| wr_bb | input | 1 | Written busy bit (1 START, 0 STOP) |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| bus_busy | output | 1 | Bus-busy flag |
| bit_cnt | output | BITCNT_W (3) | Bit counter, loaded with zero after START |
| byte_start | output | 1 | One-cycle request to the byte shifter |
| cmd_error | output | 1 | Sticky flag for a rejected START or STOP |

## Verification
The hardest case to reach is a second write that lands while a sequence is still counting. It must be dropped silently, and the counting must not be disturbed. A mode change in the middle of a sequence is equally hard to reach. The stimulus task can inject a write of the opposite command, and flip mode_fast, on a chosen cycle inside the running sequence. The bench then measures the cycle of every line and flag edge against the fixed counts of the mode that was sampled when the command was accepted.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE        = 3'd0,
      SQ_START_SETUP = 3'd1,
      SQ_START_HOLD  = 3'd2,
      SQ_STOP_HOLD   = 3'd3,
      SQ_STOP_SETUP  = 3'd4,
      SQ_STOP_FLAG   = 3'd5
   } sq_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cond_cmd_decode.sv
module cond_cmd_decode (
   input  logic enable,
   input  logic wr_stb,
   input  logic wr_mst,
   input  logic wr_trx,
   input  logic wr_bb,
   input  logic bus_busy,
   input  logic seq_idle,
   output logic acc_start,
   output logic acc_stop,
   output logic reject
);
   logic cmd_valid;
   logic start_req;
   logic stop_req;

   assign cmd_valid = enable & wr_stb & wr_mst & wr_trx & seq_idle;
   assign start_req = cmd_valid & wr_bb;
   assign stop_req  = cmd_valid & ~wr_bb;

   assign acc_start = start_req & ~bus_busy;
   assign acc_stop  = stop_req  &  bus_busy;
   assign reject    = (start_req & bus_busy) | (stop_req & ~bus_busy);
endmodule

// File: rtl/cond_timing_sel.sv
module cond_timing_sel #(
   parameter int CNT_W         = 5,
   parameter bit HAS_FAST      = 1'b1,
   parameter int STD_START_SU  = 20,
   parameter int STD_STOP_SU   = 17,
   parameter int STD_HOLD      = 20,
   parameter int STD_FLAG      = 12,
   parameter int FAST_START_SU = 10,
   parameter int FAST_STOP_SU  = 7,
   parameter int FAST_HOLD     = 10,
   parameter int FAST_FLAG     = 6
) (
   input  logic             fast,
   output logic [CNT_W-1:0] t_start_su,
   output logic [CNT_W-1:0] t_stop_su,
   output logic [CNT_W-1:0] t_hold,
   output logic [CNT_W-1:0] t_flag
);
   generate
      if (HAS_FAST) begin : g_two_modes
         assign t_start_su = fast ? CNT_W'(FAST_START_SU) : CNT_W'(STD_START_SU);
         assign t_stop_su  = fast ? CNT_W'(FAST_STOP_SU)  : CNT_W'(STD_STOP_SU);
         assign t_hold     = fast ? CNT_W'(FAST_HOLD)     : CNT_W'(STD_HOLD);
         assign t_flag     = fast ? CNT_W'(FAST_FLAG)     : CNT_W'(STD_FLAG);
      end else begin : g_std_only
         logic unused_fast;
         assign unused_fast = fast;
         assign t_start_su  = CNT_W'(STD_START_SU);
         assign t_stop_su   = CNT_W'(STD_STOP_SU);
         assign t_hold      = CNT_W'(STD_HOLD);
         assign t_flag      = CNT_W'(STD_FLAG);
      end
   endgenerate
endmodule

// File: rtl/cond_down_timer.sv
module cond_down_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             expired
);
   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (count != '0)
         count <= count - CNT_W'(1);
   end

   assign expired = (count == '0);
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
   parameter int BITCNT_W      = 3,
   parameter bit HAS_FAST      = 1'b1,
   parameter int STD_START_SU  = 20,
   parameter int STD_STOP_SU   = 17,
   parameter int STD_HOLD      = 20,
   parameter int STD_FLAG      = 12,
   parameter int FAST_START_SU = 10,
   parameter int FAST_STOP_SU  = 7,
   parameter int FAST_HOLD     = 10,
   parameter int FAST_FLAG     = 6
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                enable,
   input  logic                mode_fast,
   input  logic                wr_stb,
   input  logic                wr_mst,
   input  logic                wr_trx,
   input  logic                wr_bb,
   output logic                sda_drive_low,
   output logic                scl_drive_low,
   output logic                bus_busy,
   output logic [BITCNT_W-1:0] bit_cnt,
   output logic                byte_start,
   output logic                cmd_error
);
   import i2c_cond_pkg::*;

   localparam int MAX_STD  = max2(max2(STD_START_SU, STD_STOP_SU), max2(STD_HOLD, STD_FLAG));
   localparam int MAX_FAST = max2(max2(FAST_START_SU, FAST_STOP_SU), max2(FAST_HOLD, FAST_FLAG));
   localparam int MAX_CNT  = max2(MAX_STD, MAX_FAST);
   localparam int CNT_W    = $clog2(MAX_CNT + 1);

   generate
      if (STD_FLAG < 1 || STD_FLAG >= STD_HOLD) begin : g_bad_std_flag
         $error("standard busy-flag delay must lie in 1..hold-1");
      end
      if (FAST_FLAG < 1 || FAST_FLAG >= FAST_HOLD) begin : g_bad_fast_flag
         $error("high-speed busy-flag delay must lie in 1..hold-1");
      end
      if (STD_START_SU < 1 || STD_STOP_SU < 1 || FAST_START_SU < 1 || FAST_STOP_SU < 1) begin : g_bad_setup
         $error("setup delays must be at least one cycle");
      end
      if (BITCNT_W < 1) begin : g_bad_bitcnt
         $error("bit counter needs at least one bit");
      end
   endgenerate

   sq_state_t        state;
   logic             mode_q;
   logic             seq_idle;
   logic             acc_start;
   logic             acc_stop;
   logic             reject;
   logic             sel_fast;
   logic [CNT_W-1:0] t_start_su;
   logic [CNT_W-1:0] t_stop_su;
   logic [CNT_W-1:0] t_hold;
   logic [CNT_W-1:0] t_flag;
   logic [CNT_W-1:0] flag_mark;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic [CNT_W-1:0] tmr_count;
   logic             tmr_zero;

   assign seq_idle  = (state == SQ_IDLE);
   assign sel_fast  = seq_idle ? mode_fast : mode_q;
   assign flag_mark = t_hold - t_flag;

   cond_cmd_decode u_dec (
      .enable    (enable),
      .wr_stb    (wr_stb),
      .wr_mst    (wr_mst),
      .wr_trx    (wr_trx),
      .wr_bb     (wr_bb),
      .bus_busy  (bus_busy),
      .seq_idle  (seq_idle),
      .acc_start (acc_start),
      .acc_stop  (acc_stop),
      .reject    (reject)
   );

   cond_timing_sel #(
      .CNT_W         (CNT_W),
      .HAS_FAST      (HAS_FAST),
      .STD_START_SU  (STD_START_SU),
      .STD_STOP_SU   (STD_STOP_SU),
      .STD_HOLD      (STD_HOLD),
      .STD_FLAG      (STD_FLAG),
      .FAST_START_SU (FAST_START_SU),
      .FAST_STOP_SU  (FAST_STOP_SU),
      .FAST_HOLD     (FAST_HOLD),
      .FAST_FLAG     (FAST_FLAG)
   ) u_tsel (
      .fast       (sel_fast),
      .t_start_su (t_start_su),
      .t_stop_su  (t_stop_su),
      .t_hold     (t_hold),
      .t_flag     (t_flag)
   );

   // phase reload: a phase of N cycles loads N-1 and ends on the edge that sees zero
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         SQ_IDLE: begin
            if (acc_start) begin
               tmr_load = 1'b1;
               tmr_val  = t_start_su - CNT_W'(1);
            end else if (acc_stop) begin
               tmr_load = 1'b1;
               tmr_val  = t_hold - CNT_W'(1);
            end
         end
         SQ_START_SETUP: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = t_hold - CNT_W'(1);
            end
         end
         SQ_STOP_HOLD: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = t_stop_su - CNT_W'(1);
            end
         end
         SQ_STOP_SETUP: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = t_flag - CNT_W'(1);
            end
         end
         default: begin
            tmr_load = 1'b0;
            tmr_val  = '0;
         end
      endcase
   end

   cond_down_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .count    (tmr_count),
      .expired  (tmr_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state         <= SQ_IDLE;
         mode_q        <= 1'b0;
         sda_drive_low <= 1'b0;
         scl_drive_low <= 1'b0;
         bus_busy      <= 1'b0;
         bit_cnt       <= '1;
         byte_start    <= 1'b0;
         cmd_error     <= 1'b0;
      end else begin
         byte_start <= 1'b0;
         if (reject)
            cmd_error <= 1'b1;
         unique case (state)
            SQ_IDLE: begin
               if (acc_start) begin
                  mode_q <= mode_fast;
                  state  <= SQ_START_SETUP;
               end else if (acc_stop) begin
                  mode_q        <= mode_fast;
                  sda_drive_low <= 1'b1;
                  scl_drive_low <= 1'b1;
                  state         <= SQ_STOP_HOLD;
               end
            end
            SQ_START_SETUP: begin
               if (tmr_zero) begin
                  sda_drive_low <= 1'b1;
                  state         <= SQ_START_HOLD;
               end
            end
            SQ_START_HOLD: begin
               if (tmr_count == flag_mark)
                  bus_busy <= 1'b1;
               if (tmr_zero) begin
                  scl_drive_low <= 1'b1;
                  bit_cnt       <= '0;
                  byte_start    <= 1'b1;
                  state         <= SQ_IDLE;
               end
            end
            SQ_STOP_HOLD: begin
               if (tmr_zero) begin
                  scl_drive_low <= 1'b0;
                  state         <= SQ_STOP_SETUP;
               end
            end
            SQ_STOP_SETUP: begin
               if (tmr_zero) begin
                  sda_drive_low <= 1'b0;
                  state         <= SQ_STOP_FLAG;
               end
            end
            SQ_STOP_FLAG: begin
               if (tmr_zero) begin
                  bus_busy <= 1'b0;
                  state    <= SQ_IDLE;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk #(
   parameter int BITCNT_W = 3
) (
   input logic                clk,
   input logic                rst,
   input logic                enable,
   input logic                wr_stb,
   input logic                seq_idle,
   input logic                sda_drive_low,
   input logic                scl_drive_low,
   input logic                bus_busy,
   input logic [BITCNT_W-1:0] bit_cnt,
   input logic                byte_start,
   input logic                cmd_error
);
   // R1
   reset_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!sda_drive_low && !scl_drive_low && !bus_busy && !cmd_error && !byte_start));

   // R2
   disabled_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && !enable && seq_idle) |=>
         ($stable(sda_drive_low) && $stable(scl_drive_low) && $stable(bus_busy) && $stable(cmd_error)));

   // R3
   busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_busy) |-> (sda_drive_low && !scl_drive_low));

   // R5
   handoff_state_chk: assert property (@(posedge clk) disable iff (rst)
      byte_start |-> (scl_drive_low && sda_drive_low && bus_busy && bit_cnt == '0));

   // R5
   handoff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      byte_start |=> !byte_start);

   // R9
   sticky_error_chk: assert property (@(posedge clk) disable iff (rst)
      cmd_error |=> cmd_error);

   // R11
   busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(bus_busy) |-> (!sda_drive_low && !scl_drive_low));
endmodule

bind i2c_cond_gen i2c_cond_chk #(.BITCNT_W(BITCNT_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .enable        (enable),
   .wr_stb        (wr_stb),
   .seq_idle      (seq_idle),
   .sda_drive_low (sda_drive_low),
   .scl_drive_low (scl_drive_low),
   .bus_busy      (bus_busy),
   .bit_cnt       (bit_cnt),
   .byte_start    (byte_start),
   .cmd_error     (cmd_error)
);

// File: tb/i2c_cond_gen_test.sv
module i2c_cond_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;
   localparam int WINDOW     = 60;
   localparam int NVEC       = 6;
   // is_start, fast, expected SDA edge, SCL edge, busy edge (cycles after accepting edge)
   localparam int VEC [NVEC][5] = '{
      '{1, 0, 20, 40, 32},
      '{0, 0, 37, 20, 49},
      '{1, 1, 10, 20, 16},
      '{0, 1, 17, 10, 23},
      '{1, 1, 10, 20, 16},
      '{0, 0, 37, 20, 49}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic       mode_fast = 1'b0;
   logic       wr_stb = 1'b0;
   logic       wr_mst = 1'b0;
   logic       wr_trx = 1'b0;
   logic       wr_bb = 1'b0;
   logic       sda_drive_low;
   logic       scl_drive_low;
   logic       bus_busy;
   logic [2:0] bit_cnt;
   logic       byte_start;
   logic       cmd_error;

   int n_vec = 0;
   int n_bad = 0;
   int t_sda, t_scl, t_busy, t_pulse, n_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_cond_gen uut (
      .clk           (clk),
      .rst           (rst),
      .enable        (enable),
      .mode_fast     (mode_fast),
      .wr_stb        (wr_stb),
      .wr_mst        (wr_mst),
      .wr_trx        (wr_trx),
      .wr_bb         (wr_bb),
      .sda_drive_low (sda_drive_low),
      .scl_drive_low (scl_drive_low),
      .bus_busy      (bus_busy),
      .bit_cnt       (bit_cnt),
      .byte_start    (byte_start),
      .cmd_error     (cmd_error)
   );

   task automatic check(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   // issues one write, then records the first change of each output over WINDOW cycles
   task automatic run_cmd(input logic m, input logic t, input logic b, input logic fast,
                          input logic flip, input int inj,
                          output int o_sda, output int o_scl, output int o_busy,
                          output int o_pulse, output int o_npulse);
      logic s0, c0, b0;
      @(negedge clk);
      s0 = sda_drive_low; c0 = scl_drive_low; b0 = bus_busy;
      o_sda = -1; o_scl = -1; o_busy = -1; o_pulse = -1; o_npulse = 0;
      mode_fast = fast;
      wr_mst = m; wr_trx = t; wr_bb = b; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      for (int k = 0; k < WINDOW; k++) begin
         if (o_sda  < 0 && sda_drive_low != s0) o_sda  = k;
         if (o_scl  < 0 && scl_drive_low != c0) o_scl  = k;
         if (o_busy < 0 && bus_busy != b0)      o_busy = k;
         if (byte_start) begin
            if (o_pulse < 0) o_pulse = k;
            o_npulse++;
         end
         if (flip && k == 0) mode_fast = ~fast;
         if (k == inj) begin
            wr_mst = 1'b1; wr_trx = 1'b1; wr_bb = ~b; wr_stb = 1'b1;
         end else begin
            wr_stb = 1'b0;
         end
         @(negedge clk);
      end
      wr_stb = 1'b0;
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      finish_up();
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 sda", int'(sda_drive_low), 0);
      check("R1 scl", int'(scl_drive_low), 0);
      check("R1 busy", int'(bus_busy), 0);
      check("R1 bit_cnt", int'(bit_cnt), 7);
      check("R1 error", int'(cmd_error), 0);
      check("R1 byte_start", int'(byte_start), 0);

      // R2 disabled block ignores a START write
      enable = 1'b0;
      run_cmd(1, 1, 1, 0, 0, -1, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R2 sda", t_sda, -1);
      check("R2 scl", t_scl, -1);
      check("R2 busy", t_busy, -1);
      check("R2 error", int'(cmd_error), 0);

      // R10 write with master bit clear does nothing
      enable = 1'b1;
      run_cmd(0, 1, 1, 0, 0, -1, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R10 sda", t_sda, -1);
      check("R10 busy", t_busy, -1);
      check("R10 error", int'(cmd_error), 0);

      // R9 STOP on an idle bus
      run_cmd(1, 1, 0, 0, 0, -1, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R9 stop-idle sda", t_sda, -1);
      check("R9 stop-idle scl", t_scl, -1);
      check("R9 stop-idle error", int'(cmd_error), 1);

      do_reset();
      enable = 1'b1;

      // R3 R4 R5 R6 R7 vector walk
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         tag = (VEC[v][0] != 0) ? ((VEC[v][1] != 0) ? "R4" : "R3")
                                : ((VEC[v][1] != 0) ? "R7" : "R6");
         run_cmd(1, 1, VEC[v][0] != 0, VEC[v][1] != 0, 0, -1,
                 t_sda, t_scl, t_busy, t_pulse, n_pulse);
         check({tag, " sda edge"}, t_sda, VEC[v][2]);
         check({tag, " scl edge"}, t_scl, VEC[v][3]);
         check({tag, " busy edge"}, t_busy, VEC[v][4]);
         if (VEC[v][0] != 0) begin
            check("R5 pulse cycle", t_pulse, VEC[v][3]);
            check("R5 pulse count", n_pulse, 1);
            check("R5 bit_cnt", int'(bit_cnt), 0);
         end
      end
      check("R9 no error after legal commands", int'(cmd_error), 0);

      // R8 mode flipped mid-START, R10 STOP injected mid-START
      run_cmd(1, 1, 1, 1, 1, 3, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R8 start sda", t_sda, 10);
      check("R8 start scl", t_scl, 20);
      check("R8 start busy", t_busy, 16);
      check("R10 injected write error", int'(cmd_error), 0);

      // R9 START on a busy bus
      run_cmd(1, 1, 1, 0, 0, -1, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R9 start-busy sda", t_sda, -1);
      check("R9 start-busy scl", t_scl, -1);
      check("R9 start-busy pulse", n_pulse, 0);
      check("R9 start-busy error", int'(cmd_error), 1);

      // R8 standard STOP with mode flipped to fast, R10 START injected
      run_cmd(1, 1, 0, 0, 1, 5, t_sda, t_scl, t_busy, t_pulse, n_pulse);
      check("R8 stop scl", t_scl, 20);
      check("R8 stop sda", t_sda, 37);
      check("R8 stop busy", t_busy, 49);
      // R11 released bus, R9 error still held
      check("R11 sda", int'(sda_drive_low), 0);
      check("R11 scl", int'(scl_drive_low), 0);
      check("R11 busy", int'(bus_busy), 0);
      check("R9 sticky", int'(cmd_error), 1);

      finish_up();
   end
endmodule